// File: doc/BRIEF.md
# PWM Prescaler and Clock-Enable Generator

This block produces the timing strobes for a four-channel PWM unit from a single master clock. A free-running binary counter yields eleven power-of-two enable taps, from the master clock itself down to one pulse in every 1024 cycles. Two independent linear dividers, A and B, each take one of those taps and stretch it further by an 8-bit factor. Each channel then selects its time base from a raw tap, divided clock A or divided clock B.

Every output is a one-cycle clock-enable in the master clock domain, not a derived clock. The enables are decoded from registered state, so the waveform counters downstream can use them in the same cycle. The control word and the channel selects are plain level inputs, normally driven from configuration registers elsewhere.

Top module: `pwm_clkgen`

## Requirements
- R1: Tap k (k = 0..10) of `tap_en` is high in exactly those cycles where the low k bits of the internal free-running cycle count are all ones. Tap 0 is therefore high every cycle and tap k pulses once every 2^k cycles. The count advances by one each cycle and wraps modulo 1024.
- R2: `ctrl_word` fields: divider A factor in bits 7:0, divider A tap select in bits 11:8, divider B factor in bits 23:16, divider B tap select in bits 27:24. The other bits are ignored.
- R3: A divider whose factor is 0 produces no pulses at all.
- R4: A divider with factor 1 pulses in exactly the cycles where its selected tap pulses, except in a cycle where its configuration changes (R7).
- R5: A divider with factor N (2..255) pulses on every N-th pulse of its selected tap. It counts tap pulses from the last configuration change and pulses on the N-th, 2N-th and so on.
- R6: Divider tap select codes 0xB to 0xF are reserved and give no pulses.
- R7: When a divider's factor or tap select differs from the value seen in the previous cycle, its count restarts. A tap pulse in that cycle is not counted and gives no output.
- R8: Channel i uses `ch_sel[4i+3:4i]`. Codes 0x0 to 0xA select tap 0..10, code 0xB selects divided clock A and code 0xC selects divided clock B. Each channel selects independently of the others.
- R9: Channel select codes 0xD to 0xF are reserved and give no pulses on that channel.
- R10: A synchronous active-high `rst` clears the cycle count and both divider counts and configuration history. In the first cycle after reset only tap 0 is high, and both divided clocks are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_word | input | 32 | Divider A/B factor and tap select fields |
| ch_sel | input | 16 | Four 4-bit channel clock selects |
| tap_en | output | 11 | Power-of-two prescaler enables |
| clka_en | output | 1 | Divided clock A enable |
| clkb_en | output | 1 | Divided clock B enable |
| ch_en | output | 4 | Per-channel selected clock enable |

## Verification
Every output is decoded from registers without a further stage. A tap, divider or channel result is therefore due in the same cycle as the count state that produces it. A change on `ctrl_word` first shows as a suppressed divider output in that same cycle, and counting resumes from the next selected tap pulse. The bench drives inputs just after a rising edge and builds the expected outputs for that cycle from its own cycle count and divider model on the falling edge. The monitor compares them a moment later, so the stimulus and the sample fall into the same cycle.

// File: rtl/pwm_clkgen_pkg.sv
package pwm_clkgen_pkg;
   localparam int unsigned PCG_TAPS  = 11;
   localparam int unsigned PCG_SEL_W = 4;
   localparam int unsigned PCG_FAC_W = 8;
   localparam int unsigned PCG_CH    = 4;
   localparam int unsigned PCG_HALF  = 16;

   // channel code of the first divided clock follows the last tap code
   function automatic int unsigned code_div_a(input int unsigned ntaps);
      return ntaps;
   endfunction

   function automatic int unsigned code_div_b(input int unsigned ntaps);
      return ntaps + 1;
   endfunction
endpackage

// File: rtl/pwm_tap_chain.sv
module pwm_tap_chain #(
   parameter int unsigned NUM_TAPS = 11
) (
   input  logic                clk,
   input  logic                rst,
   output logic [NUM_TAPS-1:0] tap_en
);
   localparam int unsigned CW = NUM_TAPS - 1;

   initial begin
      if (NUM_TAPS < 2) $error("pwm_tap_chain: NUM_TAPS must be at least 2");
   end

   logic [CW-1:0] cyc_q;

   always_ff @(posedge clk) begin
      if (rst) cyc_q <= '0;
      else     cyc_q <= cyc_q + 1'b1;
   end

   assign tap_en[0] = 1'b1;

   for (genvar k = 1; k < NUM_TAPS; k++) begin : g_tap
      assign tap_en[k] = &cyc_q[k-1:0];
      if (k >= 2) begin : g_nest
         // R1: a slower tap never fires without the next faster one
         a_r1_tap_nesting: assert property (@(posedge clk) disable iff (rst)
            tap_en[k] |-> tap_en[k-1]);
      end
   end
endmodule

// File: rtl/pwm_lin_div.sv
module pwm_lin_div #(
   parameter int unsigned NUM_TAPS = 11,
   parameter int unsigned SEL_W    = 4,
   parameter int unsigned FAC_W    = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_TAPS-1:0] tap_en,
   input  logic [SEL_W-1:0]    tap_sel,
   input  logic [FAC_W-1:0]    factor,
   output logic                div_en
);
   localparam int unsigned CFG_W = SEL_W + FAC_W;

   initial begin
      if (NUM_TAPS > (1 << SEL_W)) $error("pwm_lin_div: SEL_W too narrow for NUM_TAPS");
      if (FAC_W < 1) $error("pwm_lin_div: FAC_W must be positive");
   end

   logic [FAC_W-1:0] cnt_q;
   logic [CFG_W-1:0] cfg_q;
   logic [CFG_W-1:0] cfg_now;
   logic             cfg_chg;
   logic             tap_hit;
   logic             fac_on;
   logic             at_end;

   always_comb begin
      tap_hit = 1'b0;
      for (int k = 0; k < NUM_TAPS; k++) begin
         if (tap_sel == SEL_W'(k)) tap_hit = tap_en[k];
      end
   end

   assign cfg_now = {tap_sel, factor};
   assign cfg_chg = (cfg_now != cfg_q);
   assign fac_on  = (factor != '0);
   assign at_end  = (cnt_q >= factor - 1'b1);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         cfg_q <= '0;
      end else begin
         cfg_q <= cfg_now;
         if (cfg_chg)                cnt_q <= '0;
         else if (tap_hit && fac_on) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
      end
   end

   assign div_en = tap_hit & fac_on & ~cfg_chg & at_end;

   // R3: factor zero keeps the divided clock silent
   a_r3_off_silent: assert property (@(posedge clk) disable iff (rst)
      (factor == '0) |-> !div_en);
   // R6: reserved tap codes never pulse
   a_r6_reserved_tap: assert property (@(posedge clk) disable iff (rst)
      (tap_sel >= SEL_W'(NUM_TAPS)) |-> !div_en);
   // R5: an output pulse always coincides with a pulse of the chosen tap
   a_r5_needs_tap: assert property (@(posedge clk) disable iff (rst)
      div_en |-> tap_hit);
   // R7: a configuration change restarts the count
   a_r7_restart: assert property (@(posedge clk) disable iff (rst)
      cfg_chg |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_ch_mux.sv
module pwm_ch_mux #(
   parameter int unsigned NUM_TAPS = 11,
   parameter int unsigned SEL_W    = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_TAPS-1:0] tap_en,
   input  logic                clka_en,
   input  logic                clkb_en,
   input  logic [SEL_W-1:0]    code,
   output logic                ch_en
);
   import pwm_clkgen_pkg::*;

   localparam int unsigned CODE_A = code_div_a(NUM_TAPS);
   localparam int unsigned CODE_B = code_div_b(NUM_TAPS);

   initial begin
      if (CODE_B >= (1 << SEL_W)) $error("pwm_ch_mux: SEL_W too narrow for the source codes");
   end

   always_comb begin
      ch_en = 1'b0;
      for (int k = 0; k < NUM_TAPS; k++) begin
         if (code == SEL_W'(k)) ch_en = tap_en[k];
      end
      if (code == SEL_W'(CODE_A)) ch_en = clka_en;
      if (code == SEL_W'(CODE_B)) ch_en = clkb_en;
   end

   // R9: reserved channel codes stay silent
   a_r9_reserved_code: assert property (@(posedge clk) disable iff (rst)
      (code > SEL_W'(CODE_B)) |-> !ch_en);
endmodule

// File: rtl/pwm_clkgen.sv
module pwm_clkgen
   import pwm_clkgen_pkg::*;
#(
   parameter int unsigned NUM_TAPS = PCG_TAPS,
   parameter int unsigned SEL_W    = PCG_SEL_W,
   parameter int unsigned FAC_W    = PCG_FAC_W,
   parameter int unsigned NUM_CH   = PCG_CH,
   localparam int unsigned HALF    = PCG_HALF,
   localparam int unsigned CTRL_W  = 2 * HALF
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [CTRL_W-1:0]       ctrl_word,
   input  logic [NUM_CH*SEL_W-1:0] ch_sel,
   output logic [NUM_TAPS-1:0]     tap_en,
   output logic                    clka_en,
   output logic                    clkb_en,
   output logic [NUM_CH-1:0]       ch_en
);
   initial begin
      if (FAC_W + SEL_W > HALF) $error("pwm_clkgen: divider fields overflow a control half-word");
      if (NUM_CH < 1) $error("pwm_clkgen: NUM_CH must be positive");
   end

   pwm_tap_chain #(.NUM_TAPS(NUM_TAPS)) u_taps (
      .clk(clk), .rst(rst), .tap_en(tap_en)
   );

   pwm_lin_div #(.NUM_TAPS(NUM_TAPS), .SEL_W(SEL_W), .FAC_W(FAC_W)) u_div_a (
      .clk(clk), .rst(rst), .tap_en(tap_en),
      .tap_sel(ctrl_word[FAC_W +: SEL_W]),
      .factor(ctrl_word[0 +: FAC_W]),
      .div_en(clka_en)
   );

   pwm_lin_div #(.NUM_TAPS(NUM_TAPS), .SEL_W(SEL_W), .FAC_W(FAC_W)) u_div_b (
      .clk(clk), .rst(rst), .tap_en(tap_en),
      .tap_sel(ctrl_word[HALF+FAC_W +: SEL_W]),
      .factor(ctrl_word[HALF +: FAC_W]),
      .div_en(clkb_en)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      pwm_ch_mux #(.NUM_TAPS(NUM_TAPS), .SEL_W(SEL_W)) u_mux (
         .clk(clk), .rst(rst), .tap_en(tap_en),
         .clka_en(clka_en), .clkb_en(clkb_en),
         .code(ch_sel[c*SEL_W +: SEL_W]),
         .ch_en(ch_en[c])
      );
   end

   // R10: one cycle after reset only the undivided tap is active
   a_r10_reset_state: assert property (@(posedge clk)
      rst |=> (tap_en == NUM_TAPS'(1)) && !clka_en && !clkb_en);
endmodule

// File: tb/pwm_clkgen_tb_top.sv
`timescale 1ns/100ps
module pwm_clkgen_tb_top;
   localparam int NT = 11;
   localparam int NC = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [31:0]   ctrl_word = '0;
   logic [15:0]   ch_sel = '0;
   logic [NT-1:0] tap_en;
   logic          clka_en, clkb_en;
   logic [NC-1:0] ch_en;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   always #2.5 clk = ~clk;

   pwm_clkgen dut_i (
      .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .ch_sel(ch_sel),
      .tap_en(tap_en), .clka_en(clka_en), .clkb_en(clkb_en), .ch_en(ch_en)
   );

   typedef struct packed {
      logic [NT-1:0] taps;
      logic          a;
      logic          b;
      logic [NC-1:0] ch;
   } exp_t;

   exp_t exp_q[$];

   // reference model state, derived from the requirements
   int   m_cyc = 0, m_cyc_n = 0;
   int   m_cnt[2]  = '{0, 0};
   int   m_cfg[2]  = '{0, 0};
   int   m_cnt_n[2] = '{0, 0};
   int   m_cfg_n[2] = '{0, 0};

   function automatic logic tap_of(input int cyc, input int k);
      int msk;
      msk = (1 << k) - 1;
      return ((cyc & msk) == msk);
   endfunction

   // driver: builds the expected outputs of the current cycle and pushes them
   always @(negedge clk) begin
      if (!rst) begin
         exp_t e;
         int   sel, fac, cfg;
         logic hit;
         logic dv[2];
         for (int k = 0; k < NT; k++) e.taps[k] = tap_of(m_cyc, k);
         for (int d = 0; d < 2; d++) begin
            fac = int'(ctrl_word[16*d +: 8]);
            sel = int'(ctrl_word[16*d+8 +: 4]);
            cfg = (sel << 8) | fac;
            hit = (sel < NT) ? e.taps[sel] : 1'b0;
            m_cfg_n[d] = cfg;
            if (cfg != m_cfg[d]) begin
               dv[d] = 1'b0;
               m_cnt_n[d] = 0;
            end else if (hit && fac != 0) begin
               dv[d] = (m_cnt[d] + 1 == fac);
               m_cnt_n[d] = (m_cnt[d] + 1 == fac) ? 0 : m_cnt[d] + 1;
            end else begin
               dv[d] = 1'b0;
               m_cnt_n[d] = m_cnt[d];
            end
         end
         e.a = dv[0];
         e.b = dv[1];
         for (int c = 0; c < NC; c++) begin
            int code;
            code = int'(ch_sel[4*c +: 4]);
            if (code < NT)       e.ch[c] = e.taps[code];
            else if (code == NT) e.ch[c] = e.a;
            else if (code == NT+1) e.ch[c] = e.b;
            else                 e.ch[c] = 1'b0;
         end
         m_cyc_n = (m_cyc + 1) % 1024;
         exp_q.push_back(e);
      end
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (rst) begin
         m_cyc <= 0;
         m_cnt <= '{0, 0};
         m_cfg <= '{0, 0};
      end else begin
         m_cyc <= m_cyc_n;
         m_cnt <= m_cnt_n;
         m_cfg <= m_cfg_n;
      end
   end

   // monitor: pops the expected item and compares it with the outputs
   always @(negedge clk) begin
      #1;
      while (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_checks += 3;
         if (tap_en !== e.taps) begin
            n_fail++;
            $display("FAIL R1/R10 taps: actual %h expected %h", tap_en, e.taps);
         end
         if ({clka_en, clkb_en} !== {e.a, e.b}) begin
            n_fail++;
            $display("FAIL R2,R3,R4,R5,R6,R7 dividers ctrl=%h: actual %b%b expected %b%b",
                     ctrl_word, clka_en, clkb_en, e.a, e.b);
         end
         if (ch_en !== e.ch) begin
            n_fail++;
            $display("FAIL R8,R9 channels sel=%h: actual %b expected %b", ch_sel, ch_en, e.ch);
         end
      end
   end

   task automatic run(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic cfg(input logic [3:0] sa, input logic [7:0] fa,
                      input logic [3:0] sb, input logic [7:0] fb);
      ctrl_word = {4'h0, sb, fb, 4'h0, sa, fa};
   endtask

   int pulses;

   initial begin
      ctrl_word = {4'h0, 4'h0, 8'd3, 4'h0, 4'h0, 8'd2};
      ch_sel = 16'hCB10;
      run(3);
      rst = 1'b0;
      // R10: first cycle after reset, explicit check
      @(negedge clk); #2;
      n_checks++;
      if (tap_en !== 11'h001 || clka_en !== 1'b0 || clkb_en !== 1'b0) begin
         n_fail++;
         $display("FAIL R10 reset state: actual %h/%b%b expected 001/00", tap_en, clka_en, clkb_en);
      end
      run(200);
      // R3 off, R4 factor one; channels on tap 3, A, B, reserved (R9)
      cfg(4'h0, 8'd0, 4'h2, 8'd1);
      ch_sel = 16'hDCB3;
      run(300);
      // R5 factors on fast taps, channel on slowest tap and reserved 0xE
      cfg(4'h1, 8'd3, 4'h0, 8'd5);
      ch_sel = 16'hECBA;
      run(400);
      // R6 reserved tap on A, maximum factor on B
      cfg(4'hC, 8'd4, 4'h4, 8'd255);
      ch_sel = 16'hFBC4;
      pulses = 0;
      for (int i = 0; i < 4200; i++) begin
         @(negedge clk); #2;
         if (clkb_en) pulses++;
         if (i < 4199) begin @(posedge clk); #1; end
      end
      // R5: 4200 cycles of tap 4 give 262 pulses, so 255 of them give one output
      n_checks++;
      if (pulses !== 1) begin
         n_fail++;
         $display("FAIL R5 factor 255 pulse count: actual %0d expected 1", pulses);
      end
      run(1);
      // R7 mid-run changes of factor and of tap select
      cfg(4'h0, 8'd2, 4'h0, 8'd7);
      ch_sel = 16'h0CB0;
      run(13);
      cfg(4'h0, 8'd7, 4'h0, 8'd7);
      run(40);
      cfg(4'h1, 8'd7, 4'h3, 8'd2);
      run(200);
      // R2 upper bits ignored
      ctrl_word = {4'hF, 4'h1, 8'd2, 4'hF, 4'h1, 8'd7};
      run(300);
      // R2: divider A and B fields swapped between halves
      cfg(4'h2, 8'd1, 4'h1, 8'd0);
      ch_sel = 16'h9CBB;
      run(300);
      rst = 1'b1;
      run(2);
      rst = 1'b0;
      run(100);
      @(negedge clk); #3;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule